// File: doc/BRIEF.md
# Composite video sync sequencer

This block produces the sync waveform for a progressive, PAL-style composite video field. It runs from a single 24 MHz clock. A one-bit output selects the analog level: low means the 0 V sync tip and high means the 0.3 V black level. A second output, the picture-line strobe, marks the visible part of each active line, so that a pixel source can know when to drive picture data.

A field is a fixed series of segments. Broad pulses and equalising pulses each take half a line, and picture lines take a full line. A field starts with five broad pulses. Each broad pulse is low for most of its half-line and high for a short gap. Five equalising pulses follow, each with a short low and a long high. Then come 304 picture lines, each opening with a line sync pulse and a back porch. Six more equalising pulses close the field, and the series starts again with the first broad pulse. A synchronous reset returns the block to the start of the first broad pulse at any point.

Top module: `csync_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the sync output is low and the strobe is low. The sequence then starts with the first broad pulse.
- R2: A field opens with 5 broad pulses. Each is low for 720 cycles (30 µs) and then high for 48 cycles (2 µs), for a total of one half-line of 768 cycles.
- R3: The broad pulses are followed by 5 equalising pulses. Each is low for 48 cycles and then high for 720 cycles.
- R4: Next come 304 picture lines of 1536 cycles (64 µs) each. Each line is low for its first 96 cycles (4 µs) and high for the rest of the line.
- R5: In a picture line, the strobe is high from cycle 384 of the line to the end of the line (cycles 96 to 383 are the 12 µs back porch). The strobe stays low during broad and equalising pulses.
- R6: The picture lines are followed by 6 equalising pulses, the same shape as in R3. The next segment is again the first broad pulse, and the field repeats with no gap.
- R7: A reset asserted in the middle of a field abandons it. After release, a complete field is produced again, starting from the first broad pulse.
- R8: The strobe is never high while the sync output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz timing clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_out | output | 1 | Sync level: 0 = sync tip, 1 = black level |
| line_strobe | output | 1 | High during the visible part of a picture line |

## Verification
The bench measures the length of every low and high run over full fields and compares each run with a list of expected segments. An off-by-one in a segment counter would show up as one pulse too many or too few at a phase boundary, most likely in the six trailing equalising pulses, which differ in count from the five leading ones. A wrong low-length compare would stretch or shorten the runs. A strobe that starts one cycle early or late would change the strobe count of every line. A second reset, asserted in the middle of a picture line, checks that the block restarts at a broad pulse and does not resume the line.

// File: rtl/csync_pkg.sv
package csync_pkg;

  typedef enum logic [1:0] {
    PH_BROAD   = 2'd0,
    PH_EQ_PRE  = 2'd1,
    PH_LINE    = 2'd2,
    PH_EQ_POST = 2'd3
  } phase_t;

  // Order of the phases inside a field; the last one wraps to the first.
  function automatic phase_t next_phase(phase_t p);
    case (p)
      PH_BROAD:  return PH_EQ_PRE;
      PH_EQ_PRE: return PH_LINE;
      PH_LINE:   return PH_EQ_POST;
      default:   return PH_BROAD;
    endcase
  endfunction

  // Length of one segment in clock cycles: a full line or a half-line.
  function automatic int unsigned seg_len(phase_t p, int unsigned line_cyc);
    return (p == PH_LINE) ? line_cyc : line_cyc / 2;
  endfunction

  // Number of cycles a segment holds sync low, counted from its first cycle.
  function automatic int unsigned low_len(phase_t p, int unsigned line_cyc,
                                          int unsigned broad_high,
                                          int unsigned eq_low,
                                          int unsigned line_sync);
    case (p)
      PH_BROAD: return line_cyc / 2 - broad_high;
      PH_LINE:  return line_sync;
      default:  return eq_low;
    endcase
  endfunction

  // Number of segments in each phase.
  function automatic int unsigned seg_count(phase_t p, int unsigned n_broad,
                                            int unsigned n_pre,
                                            int unsigned n_lines,
                                            int unsigned n_post);
    case (p)
      PH_BROAD:  return n_broad;
      PH_EQ_PRE: return n_pre;
      PH_LINE:   return n_lines;
      default:   return n_post;
    endcase
  endfunction

endpackage

// File: rtl/csync_timer.sv
module csync_timer
  import csync_pkg::*;
#(
  parameter int LINE_CYC = 1536,
  localparam int CW = $clog2(LINE_CYC)
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        phase,
  output logic [CW-1:0] cyc,
  output logic          seg_last
);

  assign seg_last = (cyc == CW'(seg_len(phase, LINE_CYC) - 1));

  always_ff @(posedge clk) begin
    if (rst || seg_last) cyc <= '0;
    else                 cyc <= cyc + 1'b1;
  end

  // R4
  cyc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cyc < CW'(seg_len(phase, LINE_CYC)));

endmodule

// File: rtl/csync_phase.sv
module csync_phase
  import csync_pkg::*;
#(
  parameter int N_BROAD   = 5,
  parameter int N_EQ_PRE  = 5,
  parameter int N_LINES   = 304,
  parameter int N_EQ_POST = 6,
  localparam int MAX_A = (N_BROAD > N_EQ_PRE) ? N_BROAD : N_EQ_PRE,
  localparam int MAX_B = (N_LINES > N_EQ_POST) ? N_LINES : N_EQ_POST,
  localparam int SW = $clog2(((MAX_A > MAX_B) ? MAX_A : MAX_B) + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   seg_last,
  output phase_t phase,
  output logic   phase_last
);

  logic [SW-1:0] seg_idx;

  assign phase_last = seg_last &&
    (seg_idx == SW'(seg_count(phase, N_BROAD, N_EQ_PRE, N_LINES, N_EQ_POST) - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_BROAD;
      seg_idx <= '0;
    end else if (phase_last) begin
      phase   <= next_phase(phase);
      seg_idx <= '0;
    end else if (seg_last) begin
      seg_idx <= seg_idx + 1'b1;
    end
  end

  // R6
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (phase == next_phase($past(phase))));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> $past(seg_last));

endmodule

// File: rtl/csync_shaper.sv
module csync_shaper
  import csync_pkg::*;
#(
  parameter int LINE_CYC   = 1536,
  parameter int BROAD_HIGH = 48,
  parameter int EQ_LOW     = 48,
  parameter int LINE_SYNC  = 96,
  parameter int PORCH      = 288,
  localparam int CW = $clog2(LINE_CYC),
  localparam int VIS_START = LINE_SYNC + PORCH
) (
  input  phase_t        phase,
  input  logic [CW-1:0] cyc,
  output logic          sync_out,
  output logic          line_strobe
);

  always_comb begin
    sync_out    = (cyc >= CW'(low_len(phase, LINE_CYC, BROAD_HIGH, EQ_LOW, LINE_SYNC)));
    line_strobe = (phase == PH_LINE) && (cyc >= CW'(VIS_START));
  end

endmodule

// File: rtl/csync_seq.sv
module csync_seq
  import csync_pkg::*;
#(
  parameter int LINE_CYC   = 1536,
  parameter int BROAD_HIGH = 48,
  parameter int EQ_LOW     = 48,
  parameter int LINE_SYNC  = 96,
  parameter int PORCH      = 288,
  parameter int N_BROAD    = 5,
  parameter int N_EQ_PRE   = 5,
  parameter int N_LINES    = 304,
  parameter int N_EQ_POST  = 6
) (
  input  logic clk,
  input  logic rst,
  output logic sync_out,
  output logic line_strobe
);

  localparam int CW = $clog2(LINE_CYC);

  phase_t        phase;
  logic [CW-1:0] cyc;
  logic          seg_last;
  logic          phase_last;
  logic [CW-1:0] low_run;

  csync_timer #(.LINE_CYC(LINE_CYC)) u_timer (
    .clk(clk), .rst(rst), .phase(phase), .cyc(cyc), .seg_last(seg_last)
  );

  csync_phase #(
    .N_BROAD(N_BROAD), .N_EQ_PRE(N_EQ_PRE),
    .N_LINES(N_LINES), .N_EQ_POST(N_EQ_POST)
  ) u_phase (
    .clk(clk), .rst(rst), .seg_last(seg_last),
    .phase(phase), .phase_last(phase_last)
  );

  csync_shaper #(
    .LINE_CYC(LINE_CYC), .BROAD_HIGH(BROAD_HIGH), .EQ_LOW(EQ_LOW),
    .LINE_SYNC(LINE_SYNC), .PORCH(PORCH)
  ) u_shaper (
    .phase(phase), .cyc(cyc), .sync_out(sync_out), .line_strobe(line_strobe)
  );

  // Length of the current low run, used only by the checks below.
  always_ff @(posedge clk) begin
    if (rst || sync_out) low_run <= '0;
    else                 low_run <= low_run + 1'b1;
  end

  // R8
  strobe_sync_chk: assert property (@(posedge clk) disable iff (rst)
    line_strobe |-> sync_out);

  // R3
  low_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_out) |->
      (low_run == CW'(low_len(phase, LINE_CYC, BROAD_HIGH, EQ_LOW, LINE_SYNC))));

  // R1
  reset_start_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sync_out && !line_strobe && phase == PH_BROAD));

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(phase_last) && ($past(phase) == PH_EQ_POST) |-> (phase == PH_BROAD));

endmodule

// File: tb/csync_seq_test.sv
module csync_seq_test;

  localparam int LINE  = 96;
  localparam int HALF  = LINE / 2;
  localparam int BHIGH = 4;
  localparam int EQL   = 4;
  localparam int LSYNC = 8;
  localparam int PORCH = 10;
  localparam int NB = 5, NPRE = 5, NL = 6, NPOST = 6;

  typedef struct {
    bit    lvl;
    int    len;
    int    strb;
    string tag;
  } run_t;

  logic clk = 0;
  logic rst = 1;
  logic sync_out, line_strobe;

  run_t exp_q[$];
  int   n_run = 0, n_fail = 0;
  bit   mon_en = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  csync_seq #(
    .LINE_CYC(LINE), .BROAD_HIGH(BHIGH), .EQ_LOW(EQL), .LINE_SYNC(LSYNC),
    .PORCH(PORCH), .N_BROAD(NB), .N_EQ_PRE(NPRE), .N_LINES(NL), .N_EQ_POST(NPOST)
  ) uut (
    .clk(clk), .rst(rst), .sync_out(sync_out), .line_strobe(line_strobe)
  );

  task automatic check(bit ok, string tag, string what, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(bit lvl, int len, int strb, string tag);
    run_t r;
    r.lvl = lvl; r.len = len; r.strb = strb; r.tag = tag;
    exp_q.push_back(r);
  endtask

  // Expected field, from the requirements: each segment is a low run then a high run.
  task automatic push_field();
    for (int i = 0; i < NB; i++) begin
      push(0, HALF - BHIGH, 0, "R2");
      push(1, BHIGH, 0, "R2");
    end
    for (int i = 0; i < NPRE; i++) begin
      push(0, EQL, 0, "R3");
      push(1, HALF - EQL, 0, "R3");
    end
    for (int i = 0; i < NL; i++) begin
      push(0, LSYNC, 0, "R4");
      push(1, LINE - LSYNC, LINE - (LSYNC + PORCH), "R5");
    end
    for (int i = 0; i < NPOST; i++) begin
      push(0, EQL, 0, "R6");
      push(1, HALF - EQL, 0, "R6");
    end
  endtask

  // Monitor: measures runs and compares each with the head of the queue.
  initial begin
    bit started = 0;
    bit cur = 0;
    int run = 0, strb = 0;
    forever begin
      @(negedge clk); #1;
      if (rst || !mon_en) begin
        started = 0;
      end else begin
        if (!started) begin
          started = 1; cur = sync_out; run = 1; strb = int'(line_strobe);
          check(sync_out == 1'b0, "R1", "first level after reset", int'(sync_out), 0);
          check(line_strobe == 1'b0, "R8", "strobe while sync low", int'(line_strobe), 0);
        end else if (sync_out == cur) begin
          run++; strb += int'(line_strobe);
        end else begin
          if (exp_q.size() != 0) begin
            run_t e;
            e = exp_q.pop_front();
            check(cur == e.lvl, e.tag, "run level", int'(cur), int'(e.lvl));
            check(run == e.len, e.tag, "run length", run, e.len);
            check(strb == e.strb, (e.strb != 0) ? "R5" : "R8", "strobe cycles", strb, e.strb);
          end
          cur = sync_out; run = 1; strb = int'(line_strobe);
        end
      end
    end
  end

  // Driver
  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    #1;
    check(sync_out == 1'b0, "R1", "sync during reset", int'(sync_out), 0);
    check(line_strobe == 1'b0, "R1", "strobe during reset", int'(line_strobe), 0);
    @(negedge clk);
    push_field();
    push_field();
    rst = 0;
    mon_en = 1;
    while (exp_q.size() != 0) @(posedge clk);

    // R7: reset in the middle of a picture line, then a full field again.
    mon_en = 0;
    repeat ((NB + NPRE) * HALF + 2 * LINE + LSYNC + PORCH + 5) @(negedge clk);
    #1;
    check(line_strobe == 1'b1, "R7", "strobe before mid-line reset", int'(line_strobe), 1);
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    #1;
    check(sync_out == 1'b0, "R7", "sync during mid-line reset", int'(sync_out), 0);
    check(line_strobe == 1'b0, "R7", "strobe during mid-line reset", int'(line_strobe), 0);
    @(negedge clk);
    push_field();
    rst = 0;
    mon_en = 1;
    while (exp_q.size() != 0) @(posedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule